// File: doc/BRIEF.md
# Dual-Loop Out-of-Lock Detector

This block watches the phase error of two frequency-synthesizer loops and decides, for each loop on its own, whether the loop is out of lock. It measures the error in one period of the reference. It counts the RF-rate ticks that fall while that loop's phase-difference pulse is high. A count above a threshold of 80 ticks is a bad period. The loop's flag rises on the first tick past the threshold, without waiting for the period to end. The flag falls only after eight clean reference periods in a row.

The two per-loop flags feed one open-drain pin. A mode field picks what reaches the pin: loop A only, loop B only, or either loop. A fourth mode turns lock reporting off, and a register bit then drives the pin as a plain output. The output `pin_pull_low` is the drive of the pin transistor. A 1 turns the transistor on and pulls the pin low. A loop that is powered down counts as locked, so it never holds the flag.

Top module: `dual_lock_monitor`

## Requirements
- R1: In each reference period, a loop's error count is the number of clock cycles in which both `rf_tick` and `err_pulse` are 1 for that loop. The period is bad when the count exceeds THRESH (default 80). Exactly 80 counted ticks is clean and 81 is bad.
- R2: `loop_unlocked` for a loop rises one clock after the cycle that carries the tick taking the count past THRESH. It does not wait for `ref_tick`.
- R3: An unlocked loop returns to locked one clock after the `ref_tick` that ends its eighth consecutive clean period (GOOD_CYCLES, default 8). After seven clean periods it is still unlocked.
- R4: A bad period resets the run of clean periods to zero, so eight further clean periods are needed before release.
- R5: The two loops are measured and flagged independently. Error on one loop never changes the other loop's flag.
- R6: While `pwr_dn` is 1 for a loop, that loop's flag is 0 from the next clock on, and its error count is cleared. Ticks counted before power-down do not carry over.
- R7: `pin_mode` encodes the pin source as follows: 2'b01 for loop A (bit 0), 2'b10 for loop B (bit 1), and 2'b11 for either loop unlocked. `pin_pull_low` follows the selected source with no added clock.
- R8: With `pin_mode` = 2'b00, lock reporting is off and `pin_pull_low` equals `port_bit`.
- R9: An `rf_tick` without `err_pulse`, or an `err_pulse` without `rf_tick`, is not counted.
- R10: After reset both loops report unlocked (`loop_unlocked` = 2'b11), and each error count starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| rf_tick | input | 2 | Per-loop RF-rate enable, one cycle per RF period |
| err_pulse | input | 2 | Per-loop phase-difference pulse level |
| ref_tick | input | 2 | Per-loop strobe ending a reference period |
| pwr_dn | input | 2 | Per-loop power-down |
| pin_mode | input | 2 | Pin source: 00 port, 01 loop A, 10 loop B, 11 either |
| port_bit | input | 1 | Pin value used in port mode |
| pin_pull_low | output | 1 | Open-drain transistor on (pin pulled low) |
| loop_unlocked | output | 2 | Per-loop out-of-lock status |

## Verification
The assertions check these rules on every cycle, for each loop:
- The flag rises right after an over-threshold tick.
- A loop that is powered down is locked.
- The flag does not move unless there is an over-threshold event, a period end or a power-down.
- Every release comes at the end of a period, after exactly the set number of clean periods.
- The pin follows the port bit in port mode and goes active in "either" mode.

The bench scenarios are needed for the rest:
- the exact 80/81 boundary of the count;
- a bad period breaking a run of seven clean ones;
- ticks that are filtered out when only one of the two qualifiers is present;
- counts that are lost across a power-down inside one period;
- the mapping of each loop in the single-loop pin modes.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic [1:0] {
    PIN_PORT = 2'b00,
    PIN_A    = 2'b01,
    PIN_B    = 2'b10,
    PIN_ANY  = 2'b11
  } pin_src_e;

  // One step of a counter that stops at lim.
  function automatic int unsigned sat_step(input int unsigned cur, input logic inc,
                                           input int unsigned lim);
    if (inc && cur < lim) return cur + 1;
    return cur;
  endfunction

  // Verdict of the release run: true when this clean period completes it.
  function automatic logic run_done(input int unsigned run, input int unsigned need);
    return (run + 1) >= need;
  endfunction

endpackage

// File: rtl/phase_err_meter.sv
module phase_err_meter
  import lockdet_pkg::*;
#(
  parameter int THRESH = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rf_tick,
  input  logic err_pulse,
  input  logic ref_tick,
  input  logic pwr_dn,
  output logic over,
  output logic period_end
);
  localparam int LIM = THRESH + 1;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_eval;
  logic          tick_hit;

  assign tick_hit   = rf_tick & err_pulse;
  assign cnt_eval   = CW'(sat_step(int'(cnt_q), tick_hit, LIM));
  assign over       = ~pwr_dn & (int'(cnt_eval) > THRESH);
  assign period_end = ~pwr_dn & ref_tick;

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_dn || ref_tick) cnt_q <= '0;
    else                              cnt_q <= cnt_eval;
  end
endmodule

// File: rtl/lock_hysteresis.sv
module lock_hysteresis
  import lockdet_pkg::*;
#(
  parameter int GOOD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic over,
  input  logic period_end,
  input  logic pwr_dn,
  output logic unlocked
);
  localparam int GW = $clog2(GOOD_CYCLES) + 1;

  logic [GW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b1;
      run_q    <= '0;
    end else if (pwr_dn) begin
      unlocked <= 1'b0;
      run_q    <= '0;
    end else if (over) begin
      unlocked <= 1'b1;
      run_q    <= '0;
    end else if (period_end && unlocked) begin
      if (run_done(int'(run_q), GOOD_CYCLES)) begin
        unlocked <= 1'b0;
        run_q    <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pin_select.sv
module pin_select
  import lockdet_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] unlocked,
  input  logic       port_bit,
  output logic       pull_low
);
  always_comb begin
    unique case (pin_src_e'(mode))
      PIN_A:   pull_low = unlocked[0];
      PIN_B:   pull_low = unlocked[1];
      PIN_ANY: pull_low = |unlocked;
      default: pull_low = port_bit;
    endcase
  end
endmodule

// File: rtl/dual_lock_monitor.sv
module dual_lock_monitor #(
  parameter int THRESH      = 80,
  parameter int GOOD_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rf_tick,
  input  logic [1:0] err_pulse,
  input  logic [1:0] ref_tick,
  input  logic [1:0] pwr_dn,
  input  logic [1:0] pin_mode,
  input  logic       port_bit,
  output logic       pin_pull_low,
  output logic [1:0] loop_unlocked
);
  localparam int NL = 2;

  logic [NL-1:0] over_w;
  logic [NL-1:0] end_w;

  for (genvar g = 0; g < NL; g++) begin : g_loop
    phase_err_meter #(.THRESH(THRESH)) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .rf_tick   (rf_tick[g]),
      .err_pulse (err_pulse[g]),
      .ref_tick  (ref_tick[g]),
      .pwr_dn    (pwr_dn[g]),
      .over      (over_w[g]),
      .period_end(end_w[g])
    );
    lock_hysteresis #(.GOOD_CYCLES(GOOD_CYCLES)) u_hyst (
      .clk       (clk),
      .rst_n     (rst_n),
      .over      (over_w[g]),
      .period_end(end_w[g]),
      .pwr_dn    (pwr_dn[g]),
      .unlocked  (loop_unlocked[g])
    );
  end

  pin_select u_pin (
    .mode    (pin_mode),
    .unlocked(loop_unlocked),
    .port_bit(port_bit),
    .pull_low(pin_pull_low)
  );
endmodule

// File: rtl/dual_lock_monitor_chk.sv
module dual_lock_monitor_chk #(
  parameter int GOOD_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pwr_dn,
  input logic [1:0] pin_mode,
  input logic       port_bit,
  input logic       pin_pull_low,
  input logic [1:0] loop_unlocked,
  input logic [1:0] over_w,
  input logic [1:0] end_w
);
  localparam int GW = $clog2(GOOD_CYCLES) + 1;

  a_r8_port_mode: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mode == 2'b00 |-> pin_pull_low == port_bit);

  a_r7_either_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode == 2'b11 && loop_unlocked != 2'b00) |-> pin_pull_low);

  for (genvar g = 0; g < 2; g++) begin : g_chk
    logic [GW-1:0] clean_q;

    always_ff @(posedge clk) begin
      if (!rst_n || pwr_dn[g] || over_w[g]) clean_q <= '0;
      else if (end_w[g] && clean_q < GW'(GOOD_CYCLES)) clean_q <= clean_q + 1'b1;
    end

    a_r2_fast_set: assert property (@(posedge clk) disable iff (!rst_n)
      over_w[g] |=> loop_unlocked[g]);

    a_r6_pd_locked: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn[g] |=> !loop_unlocked[g]);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!over_w[g] && !end_w[g] && !pwr_dn[g]) |=> $stable(loop_unlocked[g]));

    a_r3_release_run: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(loop_unlocked[g]) && !$past(pwr_dn[g]))
        |-> ($past(end_w[g]) && clean_q == GW'(GOOD_CYCLES)));
  end
endmodule

bind dual_lock_monitor dual_lock_monitor_chk #(.GOOD_CYCLES(GOOD_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_dn       (pwr_dn),
  .pin_mode     (pin_mode),
  .port_bit     (port_bit),
  .pin_pull_low (pin_pull_low),
  .loop_unlocked(loop_unlocked),
  .over_w       (over_w),
  .end_w        (end_w)
);

// File: tb/tb_dual_lock_monitor.sv
module tb_dual_lock_monitor;
  localparam int TH   = 80;
  localparam int GOOD = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rf_tick, err_pulse, ref_tick, pwr_dn, pin_mode;
  logic       port_bit;
  logic       pin_pull_low;
  logic [1:0] loop_unlocked;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dual_lock_monitor #(.THRESH(TH), .GOOD_CYCLES(GOOD)) dut (
    .clk(clk), .rst_n(rst_n), .rf_tick(rf_tick), .err_pulse(err_pulse),
    .ref_tick(ref_tick), .pwr_dn(pwr_dn), .pin_mode(pin_mode),
    .port_bit(port_bit), .pin_pull_low(pin_pull_low), .loop_unlocked(loop_unlocked)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One reference period: na/nb qualified ticks, then the ref strobe.
  task automatic run_period(input int na, input int nb);
    int len;
    len = (na > nb ? na : nb) + 2;
    for (int k = 0; k < len; k++) begin
      rf_tick   = {k < nb, k < na};
      err_pulse = {k < nb, k < na};
      ref_tick  = (k == len - 1) ? 2'b11 : 2'b00;
      @(negedge clk);
    end
    rf_tick = 2'b00; err_pulse = 2'b00; ref_tick = 2'b00;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rf_tick = 0; err_pulse = 0; ref_tick = 0; pwr_dn = 0;
    pin_mode = 2'b11; port_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset flags", loop_unlocked, 2'b11);
    check("R10 reset pin", {1'b0, pin_pull_low}, 2'b01);
  endtask

  task automatic t_first_lock;
    for (int p = 0; p < GOOD - 1; p++) run_period(0, 0);
    check("R3 seven clean periods", loop_unlocked, 2'b11);
    run_period(0, 0);
    check("R3 eighth clean period", loop_unlocked, 2'b00);
  endtask

  task automatic t_boundary;
    run_period(TH, 5);
    check("R1 exactly threshold is clean", loop_unlocked, 2'b00);
    run_period(TH + 1, 5);
    check("R1/R5 threshold+1 flags A only", loop_unlocked, 2'b01);
  endtask

  task automatic t_pin_modes;
    pin_mode = 2'b01; #1;
    check("R7 mode A", {1'b0, pin_pull_low}, 2'b01);
    pin_mode = 2'b10; #1;
    check("R7 mode B", {1'b0, pin_pull_low}, 2'b00);
    pin_mode = 2'b11; #1;
    check("R7 mode either", {1'b0, pin_pull_low}, 2'b01);
    pin_mode = 2'b00; port_bit = 1'b0; #1;
    check("R8 port bit 0", {1'b0, pin_pull_low}, 2'b00);
    port_bit = 1'b1; #1;
    check("R8 port bit 1", {1'b0, pin_pull_low}, 2'b01);
    pin_mode = 2'b11; port_bit = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_run_reset;
    for (int p = 0; p < GOOD - 1; p++) run_period(0, 0);
    run_period(90, 0);
    check("R4 bad period keeps flag", loop_unlocked, 2'b01);
    for (int p = 0; p < GOOD - 1; p++) run_period(0, 0);
    check("R4 run restarted, seven clean", loop_unlocked, 2'b01);
    run_period(0, 0);
    check("R4 release after eight more", loop_unlocked, 2'b00);
  endtask

  task automatic t_fast_set;
    for (int k = 0; k < TH; k++) begin
      rf_tick = 2'b10; err_pulse = 2'b10; @(negedge clk);
    end
    check("R2 at threshold no flag", loop_unlocked, 2'b00);
    @(negedge clk);
    rf_tick = 2'b10; err_pulse = 2'b10; @(negedge clk);
    rf_tick = 2'b00; err_pulse = 2'b00;
    check("R2 flag before period end", loop_unlocked, 2'b10);
    run_period(0, 0);
  endtask

  task automatic t_filter;
    for (int p = 0; p < GOOD; p++) run_period(0, 0);
    check("R9 precondition locked", loop_unlocked, 2'b00);
    for (int k = 0; k < 100; k++) begin
      rf_tick = 2'b01; err_pulse = 2'b10; @(negedge clk);
    end
    for (int k = 0; k < 100; k++) begin
      rf_tick = 2'b10; err_pulse = 2'b01; @(negedge clk);
    end
    rf_tick = 0; err_pulse = 0; ref_tick = 2'b11; @(negedge clk);
    ref_tick = 0;
    check("R9 unqualified ticks ignored", loop_unlocked, 2'b00);
  endtask

  task automatic t_power_down;
    run_period(0, TH + 10);
    check("R6 precondition B unlocked", loop_unlocked, 2'b10);
    pwr_dn = 2'b10; @(negedge clk);
    check("R6 powered-down loop locked", loop_unlocked, 2'b00);
    run_period(0, 120);
    check("R6 errors ignored while down", loop_unlocked, 2'b00);
    pwr_dn = 2'b00;
    for (int k = 0; k < 50; k++) begin
      rf_tick = 2'b10; err_pulse = 2'b10; @(negedge clk);
    end
    pwr_dn = 2'b10; rf_tick = 0; err_pulse = 0; @(negedge clk);
    pwr_dn = 2'b00;
    run_period(0, 50);
    check("R6 count cleared by power-down", loop_unlocked, 2'b00);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_lock();
    t_boundary();
    t_pin_modes();
    t_run_reset();
    t_fast_set();
    t_filter();
    t_power_down();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule